// File: doc/BRIEF.md
# Paged Effective Address Generator

This block works out the operand address of a memory-reference instruction in a machine with 12-bit words and addresses. Memory is divided into 32 pages of 128 words. The instruction carries a 7-bit in-page offset and a page-select bit that chooses between page zero and the page holding the instruction. An indirect bit turns that direct address into a pointer: the word stored at the pointer becomes the effective address.

Eight pointer locations, 0010 to 0017 octal, are autoindexing. An indirect reference through one of them reads the word and adds one to it. The block writes the incremented word back to the same location and uses it as the effective address. Every memory access waits on a ready handshake, so memories of any speed can be attached.

The sequencer raises `start` with the instruction and its fetch address. It collects `ea` when `done` pulses. It then performs the operation itself, which is outside this block.

Top module: `paged_ea_gen`

## Requirements
- R1: When instruction bit 7 (page select, in [11:0] numbering) is 0, the direct address is the offset in bits 6:0 with bits 11:7 zero.
- R2: When bit 7 is 1, the direct address takes bits 11:7 from `fetch_addr` and bits 6:0 from the offset. For example, an instruction fetched from 4610 octal with offset 123 octal gives 4723 octal.
- R3: When bit 8 (indirect) is 0, `done` pulses exactly one cycle after `start` is sampled, `ea` holds the direct address, and no memory access takes place.
- R4: When bit 8 is 1 and the direct address lies outside 0010-0017 octal, exactly one read takes place at the direct address, there is no write, and `ea` equals the word read.
- R5: When bit 8 is 1 and the direct address lies in 0010-0017 octal, one read is followed by one write to the same address. The word written is the word read plus one, `ea` equals that word, and `autoinc` is 1 while `done` is high.
- R6: The autoindex increment wraps modulo 4096, so a stored 7777 octal yields 0000.
- R7: `mem_req` stays high with a stable address and write flag until `mem_ready` is seen. `done` follows only after every access of the reference has completed, whatever the memory latency.
- R8: Opcode bits 11:9 have no effect on the address computed or on the accesses made.
- R9: After reset, `done`, `mem_req`, `autoinc` and `ea` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin address generation (sampled when idle) |
| instr | input | 12 | Instruction word |
| fetch_addr | input | 12 | Address the instruction was fetched from |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 12 | Write data |
| mem_rdata | input | 12 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| ea | output | 12 | Effective address, valid from done |
| done | output | 1 | One-cycle completion pulse |
| autoinc | output | 1 | Last reference wrote back an autoindex pointer |

## Verification
The bench sweeps every 7-bit offset under every combination of the indirect and page-select bits. It does this for several fetch addresses, including the first and last pages, so page-zero and current-page forms cannot be confused. Opcodes rotate across the sweep, and memory latency varies from zero to two wait cycles, which separates handshake timing from address logic. The autoindex window is probed at its edges (0007, 0010, 0017 and 0020 octal), and a forced 7777 pointer exercises the wrap.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int ADDR_W = 12;
  localparam int OFS_W  = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} ea_state_t;

  function automatic logic [ADDR_W-1:0] direct_addr(
      input logic [OFS_W-1:0] ofs, input logic cur_page,
      input logic [ADDR_W-1:0] fetch);
    logic [ADDR_W-OFS_W-1:0] pg;
    pg = cur_page ? fetch[ADDR_W-1:OFS_W] : '0;
    return {pg, ofs};
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input int base, input int count);
    return (int'(a) >= base) && (int'(a) < base + count);
  endfunction

  function automatic logic [ADDR_W-1:0] bump(input logic [ADDR_W-1:0] w);
    return w + 1'b1;
  endfunction
endpackage

// File: rtl/ea_direct.sv
module ea_direct
  import ea_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = OFS_W
) (
  input  logic [AW-1:0] instr,
  input  logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] daddr,
  output logic          indirect
);
  localparam int PSEL_BIT = OW;
  localparam int IND_BIT  = OW + 1;

  always_comb begin
    daddr    = direct_addr(instr[OW-1:0], instr[PSEL_BIT], fetch_addr);
    indirect = instr[IND_BIT];
  end
endmodule

// File: rtl/ea_seq.sv
module ea_seq
  import ea_pkg::*;
#(
  parameter int AW         = ADDR_W,
  parameter int AUTO_BASE  = 8,
  parameter int AUTO_COUNT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] daddr,
  input  logic          indirect,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic [AW-1:0] ea,
  output logic          done,
  output logic          autoinc,
  output logic          idle
);
  ea_state_t     st_q;
  logic [AW-1:0] ptr_q, ea_q;
  logic          auto_q, done_q;
  logic          ptr_auto;

  assign ptr_auto = in_window(ptr_q, AUTO_BASE, AUTO_COUNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      ea_q   <= '0;
      auto_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          auto_q <= 1'b0;
          if (indirect) begin
            ptr_q <= daddr;
            st_q  <= ST_READ;
          end else begin
            ea_q   <= daddr;
            done_q <= 1'b1;
          end
        end
        ST_READ: if (mem_ready) begin
          if (ptr_auto) begin
            ea_q <= bump(mem_rdata);
            st_q <= ST_WRITE;
          end else begin
            ea_q   <= mem_rdata;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
        ST_WRITE: if (mem_ready) begin
          auto_q <= 1'b1;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req   = (st_q != ST_IDLE);
  assign mem_we    = (st_q == ST_WRITE);
  assign mem_addr  = ptr_q;
  assign mem_wdata = ea_q;
  assign ea        = ea_q;
  assign done      = done_q;
  assign autoinc   = auto_q;
  assign idle      = (st_q == ST_IDLE);
endmodule

// File: rtl/paged_ea_gen.sv
module paged_ea_gen
  import ea_pkg::*;
#(
  parameter int AW         = ADDR_W,
  parameter int OW         = OFS_W,
  parameter int AUTO_BASE  = 8,
  parameter int AUTO_COUNT = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] instr,
  input  logic [AW-1:0] fetch_addr,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] mem_wdata,
  input  logic [AW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic [AW-1:0] ea,
  output logic          done,
  output logic          autoinc
);
  logic [AW-1:0] daddr;
  logic          indirect;
  logic          idle;

  ea_direct #(.AW(AW), .OW(OW)) u_direct (
    .instr(instr), .fetch_addr(fetch_addr), .daddr(daddr), .indirect(indirect)
  );

  ea_seq #(.AW(AW), .AUTO_BASE(AUTO_BASE), .AUTO_COUNT(AUTO_COUNT)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .daddr(daddr), .indirect(indirect),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .ea(ea), .done(done), .autoinc(autoinc), .idle(idle)
  );
endmodule

// File: rtl/paged_ea_gen_chk.sv
module paged_ea_gen_chk #(
  parameter int AW = 12,
  parameter int OW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] instr,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic          done,
  input logic          autoinc,
  input logic          idle
);
  // R3: a direct reference finishes next cycle without touching memory
  a_r3_direct_done: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && start && !instr[OW+1]) |=> (done && !mem_req));

  // R7: a pending access holds its request, address and direction
  a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R5: a write-back is entered only right after a completed read
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we) |-> $past(mem_req && mem_ready && !mem_we));

  // R5: the autoindex flag with done means a write just completed
  a_r5_flag_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (done && autoinc) |-> $past(mem_we && mem_ready));

  // R3: done is a single-cycle pulse
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind paged_ea_gen paged_ea_gen_chk #(.AW(AW), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .mem_req(mem_req),
  .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready), .done(done),
  .autoinc(autoinc), .idle(idle)
);

// File: tb/tb_paged_ea_gen.sv
module tb_paged_ea_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [11:0] instr = '0, fetch_addr = '0;
  logic        mem_req, mem_we, mem_ready, done, autoinc;
  logic [11:0] mem_addr, mem_wdata, mem_rdata, ea;

  int checks = 0, errors = 0;
  int lat_cfg = 0, wcnt = 0, rd_n = 0, wr_n = 0, cycles = 0;
  logic [11:0] wa, wd;
  logic        ovr_en = 1'b0;
  logic [11:0] ovr_a = '0, ovr_v = '0;

  always #5 clk = ~clk;

  paged_ea_gen dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .fetch_addr(fetch_addr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .ea(ea), .done(done), .autoinc(autoinc)
  );

  function automatic logic [11:0] mem_word(input logic [11:0] a);
    if (ovr_en && a == ovr_a) return ovr_v;
    return 12'((int'(a) * 5 + 3) % 4096);
  endfunction

  assign mem_rdata = mem_word(mem_addr);
  assign mem_ready = mem_req && (wcnt >= lat_cfg);

  always @(posedge clk) begin
    cycles++;
    if (!mem_req || mem_ready) wcnt <= 0; else wcnt <= wcnt + 1;
    if (mem_req && mem_ready) begin
      if (mem_we) begin wr_n++; wa = mem_addr; wd = mem_wdata; end
      else rd_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0o expected %0o", tag, act, exp);
    end
  endtask

  task automatic run(input logic [11:0] ins, input logic [11:0] fa, input int lat);
    int cyc;
    int eda, eea, erd, ewr;
    bit eauto;
    @(negedge clk);
    lat_cfg = lat; instr = ins; fetch_addr = fa; start = 1'b1;
    rd_n = 0; wr_n = 0;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 50) begin @(negedge clk); cyc++; end
    // expected: R1/R2 page choice, R4/R5/R6 pointer handling
    eda = ins[7] ? (int'(fa) / 128) * 128 + int'(ins[6:0]) : int'(ins[6:0]);
    if (!ins[8]) begin eea = eda; erd = 0; ewr = 0; eauto = 0; end
    else begin
      eea = int'(mem_word(12'(eda)));
      erd = 1; ewr = 0; eauto = 0;
      if (eda >= 8 && eda <= 15) begin eea = (eea + 1) % 4096; ewr = 1; eauto = 1; end
    end
    chk(done, "R7 done seen", int'(done), 1);
    chk(int'(ea) == eea, ins[8] ? (eauto ? "R5 ea" : "R4 ea") : (ins[7] ? "R2 ea" : "R1 ea"),
        int'(ea), eea);
    chk(rd_n == erd && wr_n == ewr, "R7 access count", rd_n * 8 + wr_n, erd * 8 + ewr);
    chk(autoinc == eauto, "R5 autoinc", int'(autoinc), int'(eauto));
    if (!ins[8]) chk(cyc == 1, "R3 done latency", cyc, 1);
    if (ewr == 1) chk(wa == 12'(eda) && int'(wd) == eea, "R5 writeback", int'(wd), eea);
    @(negedge clk);
    chk(!done, "R3 done pulse", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(!done && !mem_req && !autoinc && ea == 0, "R9 reset", int'(ea), 0);
    rst_n = 1'b1;
    // R2: worked example 4610 octal, offset 123 octal -> 4723 octal
    run(12'o2323, 12'o4610, 0);
    chk(ea == 12'o4723, "R2 example", int'(ea), 'o4723);
    // R6: wrap of 7777 through autoindex location 0012
    ovr_en = 1'b1; ovr_a = 12'o0012; ovr_v = 12'o7777;
    run(12'o1412, 12'o3000, 1);
    chk(ea == 12'o0000 && wd == 12'o0000, "R6 wrap", int'(ea), 0);
    ovr_en = 1'b0;
    // window edges: 0007, 0010, 0017, 0020
    run(12'o0407, 12'o0200, 2);
    run(12'o0410, 12'o0200, 0);
    run(12'o0417, 12'o0200, 2);
    run(12'o0420, 12'o0200, 1);
    // sweep: R1 R2 R3 R4 R5 R7, opcodes rotated for R8
    for (int fi = 0; fi < 4; fi++) begin
      logic [11:0] fa;
      fa = (fi == 0) ? 12'o0005 : (fi == 1) ? 12'o4610 : (fi == 2) ? 12'o7777 : 12'o1234;
      for (int mode = 0; mode < 4; mode++)
        for (int ofs = 0; ofs < 128; ofs++) begin
          logic [11:0] ins;
          ins = {3'((ofs + fi + mode) % 6), mode[1], mode[0], 7'(ofs)};
          run(ins, fa, (ofs + mode) % 3);
        end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule